// File: doc/BRIEF.md
# Masked Packed Absolute-Value Datapath

This block takes a 512-bit source vector and treats it as packed two's-complement integers of 8, 16, 32 or 64 bits. It writes the unsigned magnitude of each element into a destination vector. A per-lane mask can hold a lane's earlier destination value or force it to zero. For 32-bit and 64-bit elements, element 0 of the source can be sent to every lane. Only the selected active length (128, 256 or 512 bits) is computed. The rest of the destination is cleared, except in legacy mode, where it keeps the old destination contents.

The caller presents the operands together with a one-cycle `start` pulse. On the next clock edge the result register loads and `valid` goes high for that one cycle. Instruction decode, memory access, exceptions and the register file all live outside the block. The caller supplies the old destination vector as an input.

Top module: `vec_abs_unit`

## Requirements
- R1: For each element size (`esize` 0=8, 1=16, 2=32, 3=64 bits), every computed lane holds the unsigned magnitude of its signed source element.
- R2: The most negative value of each width (only the top bit set) passes through unchanged and reads as 2^(W-1). No saturation is applied.
- R3: Lane j occupies bits [j*W+W-1 : j*W] and uses mask bit j. The active length is given by `vlen` (0=128, 1=256, 2=512 bits; 3 behaves as 512), and the lane count is that length divided by W.
- R4: With `mask_en` low, every lane inside the active length is computed, whatever the value of `lane_mask`.
- R5: With `mask_en` high and `zero_mode` low, a lane whose mask bit is 0 keeps the matching bits of `old_dst`.
- R6: With `mask_en` high and `zero_mode` high, a lane whose mask bit is 0 becomes zero.
- R7: With `bcast` high and 32-bit or 64-bit elements, every computed lane takes the magnitude of source element 0.
- R8: `bcast` has no effect with 8-bit or 16-bit elements.
- R9: With `legacy` low, all destination bits from the active length up to bit 511 are zero.
- R10: With `legacy` high, the active length is 128 bits and bits 511:128 equal `old_dst`. In this mode `vlen`, `mask_en` and `bcast` are ignored.
- R11: Mask bits at or above the lane count have no effect on the result.
- R12: `dst` loads in the cycle after `start` is high, and `valid` is high for exactly that cycle. Without `start`, `dst` holds its value.
- R13: During reset, `dst` is zero and `valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operands valid; load the result on the next edge |
| src | input | 512 | Packed signed source elements |
| old_dst | input | 512 | Previous destination contents |
| lane_mask | input | 64 | Per-lane write mask, bit j for lane j |
| esize | input | 2 | Element size: 0=8, 1=16, 2=32, 3=64 bits |
| vlen | input | 2 | Active length: 0=128, 1=256, 2 or 3=512 bits |
| mask_en | input | 1 | Apply `lane_mask` |
| zero_mode | input | 1 | Masked-off lanes become zero instead of merging |
| bcast | input | 1 | Send source element 0 to every lane (32/64-bit only) |
| legacy | input | 1 | 128-bit operation that preserves the upper destination bits |
| dst | output | 512 | Result register |
| valid | output | 1 | One-cycle result strobe |

## Verification
The bench drives the most negative value of every width. A design that negates with saturation, or that sign-extends wrongly, would return 0x7F-style or corrupted patterns instead of the input pattern. It requests broadcast with byte and halfword elements, where a design that applies broadcast regardless of size would smear element 0 across all lanes. It runs a 64-bit, 128-bit case with mask bits set above lane 1, where a design that indexes the mask past the lane count would change the output. It also mixes legacy mode with masking, broadcast and a 512-bit length, where a faulty design would clear or overwrite the preserved upper 384 bits.

// File: rtl/vec_abs_unit.sv
module vec_abs_unit #(
  parameter int VW    = 512,
  parameter int BASEW = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VW-1:0]   src,
  input  logic [VW-1:0]   old_dst,
  input  logic [VW/8-1:0] lane_mask,
  input  logic [1:0]      esize,
  input  logic [1:0]      vlen,
  input  logic            mask_en,
  input  logic            zero_mode,
  input  logic            bcast,
  input  logic            legacy,
  output logic [VW-1:0]   dst,
  output logic            valid
);
  localparam int NCHUNK = VW / BASEW;

  logic [3:0][VW-1:0] res;
  logic [VW-1:0]      region, picked, nxt;
  logic [1:0]         vl_eff;
  logic               mask_on, bc_on;

  assign mask_on = mask_en & ~legacy;
  assign bc_on   = bcast & ~legacy;
  assign vl_eff  = legacy ? 2'd0 : ((vlen == 2'd3) ? 2'd2 : vlen);

  for (genvar g = 0; g < 4; g++) begin : g_w
    localparam int W = 8 << g;
    localparam int N = VW / W;
    for (genvar j = 0; j < N; j++) begin : g_l
      logic [W-1:0] op, mag;
      logic         hold;
      if (g >= 2) begin : g_bc
        assign op = bc_on ? src[W-1:0] : src[j*W +: W];
      end else begin : g_nobc
        assign op = src[j*W +: W];
      end
      assign mag  = op[W-1] ? (~op + 1'b1) : op;
      assign hold = mask_on & ~lane_mask[j];
      assign res[g][j*W +: W] = hold ? (zero_mode ? '0 : old_dst[j*W +: W]) : mag;
    end
  end

  always_comb begin
    region = '0;
    for (int i = 0; i < NCHUNK; i++)
      if (i < (1 << vl_eff)) region[i*BASEW +: BASEW] = '1;
  end

  assign picked = res[esize];
  assign nxt    = (picked & region) | (legacy ? (old_dst & ~region) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= start;
      if (start) dst <= nxt;
    end
  end

  // R12
  start_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!valid && $stable(dst)));

  // R9
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !legacy && vlen == 2'd0) |=> (dst[VW-1:BASEW] == '0));

  // R10
  legacy_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(legacy)) |-> (dst[VW-1:BASEW] == $past(old_dst[VW-1:BASEW])));

  // R6
  zero_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mask_en && zero_mode && !legacy && !lane_mask[0]) |=> (dst[7:0] == 8'h00));
endmodule

// File: tb/vec_abs_unit_bench.sv
`timescale 1ns/1ps
module vec_abs_unit_bench;
  typedef struct packed {
    logic [1:0]  es;
    logic [1:0]  vl;
    logic        me;
    logic        zm;
    logic        bc;
    logic        lg;
    logic [63:0] mk;
    logic [31:0] seed;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 32'd1},
    '{2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 32'd2},
    '{2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 32'd3},
    '{2'd3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 32'd4},
    '{2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 64'hA5A5_0F0F_3C3C_9999, 32'd5},
    '{2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_C3A1, 32'd6},
    '{2'd2, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 32'd7},
    '{2'd3, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 64'h5, 32'd8},
    '{2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 32'd9},
    '{2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 32'd10},
    '{2'd2, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 64'h0, 32'd11},
    '{2'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 32'd12},
    '{2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 32'd13}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [511:0] src = '0, old_dst = '0, dst;
  logic [63:0]  lane_mask = '0;
  logic [1:0]   esize = '0, vlen = '0;
  logic mask_en = 0, zero_mode = 0, bcast = 0, legacy = 0, valid;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vec_abs_unit u_vec_abs_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .src(src), .old_dst(old_dst),
    .lane_mask(lane_mask), .esize(esize), .vlen(vlen), .mask_en(mask_en),
    .zero_mode(zero_mode), .bcast(bcast), .legacy(legacy), .dst(dst), .valid(valid));

  function automatic logic [511:0] gen(input logic [31:0] seed);
    logic [511:0] r;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] x;
      x = seed * 32'h9E37_79B1 + i * 32'h7F4A_7C15;
      x = x ^ (x >> 13) ^ (x << 7);
      r[i*32 +: 32] = x;
    end
    return r;
  endfunction

  function automatic logic [511:0] model(input vec_t v, input logic [511:0] s, input logic [511:0] o);
    logic [511:0] r;
    int w, bits, n;
    w = 8 << v.es;
    bits = v.lg ? 128 : (v.vl == 2'd0 ? 128 : (v.vl == 2'd1 ? 256 : 512));
    n = bits / w;
    r = v.lg ? o : '0;
    for (int j = 0; j < n; j++) begin
      logic [63:0] e, m;
      logic on;
      e = '0;
      for (int b = 0; b < w; b++)
        e[b] = (v.bc && !v.lg && w >= 32) ? s[b] : s[j*w + b];
      m = e[w-1] ? (64'd0 - (e | ~((64'd1 << w) - 64'd1))) : e;
      if (w == 64) m = e[63] ? (64'd0 - e) : e;
      on = v.lg || !v.me || v.mk[j];
      for (int b = 0; b < w; b++)
        r[j*w + b] = on ? m[b] : (v.zm ? 1'b0 : o[j*w + b]);
    end
    return r;
  endfunction

  function automatic string tag_of(input vec_t v);
    if (v.lg) return "R10";
    if (v.bc) return (v.es >= 2'd2) ? "R7" : "R8";
    if (v.me) return v.zm ? "R6" : "R5";
    return "R1/R3/R4";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input logic [511:0] s, input logic [511:0] o,
                     input string tag, output logic [511:0] got);
    logic [511:0] exp;
    exp = model(v, s, o);
    @(negedge clk);
    esize = v.es; vlen = v.vl; mask_en = v.me; zero_mode = v.zm;
    bcast = v.bc; legacy = v.lg; lane_mask = v.mk; src = s; old_dst = o;
    start = 1;
    @(posedge clk); #1;
    got = dst;
    chk(dst === exp, tag, dst, exp);
    chk(valid === 1'b1, "R12 valid", {511'd0, valid}, 512'd1);
    @(negedge clk);
    start = 0; src = ~s; old_dst = ~o;
    @(posedge clk); #1;
    chk(valid === 1'b0, "R12 pulse", {511'd0, valid}, 512'd0);
    chk(dst === got, "R12 hold", dst, got);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [511:0] got, got2, mn;
    vec_t v;
    repeat (3) @(posedge clk);
    #1;
    chk(dst === '0, "R13 dst", dst, '0);
    chk(valid === 1'b0, "R13 valid", {511'd0, valid}, 512'd0);
    @(negedge clk); rst_n = 1;

    for (int k = 0; k < NV; k++) begin
      run(TBL[k], gen(TBL[k].seed), gen(TBL[k].seed + 32'd1000), tag_of(TBL[k]), got);
      if (!TBL[k].lg && TBL[k].vl < 2'd2)
        chk(got[511:256] === '0 && (TBL[k].vl == 2'd1 || got[255:128] === '0),
            "R9 upper", got, '0);
    end

    // R2: most negative pattern per width maps to itself
    for (int e = 0; e < 4; e++) begin
      int w;
      w = 8 << e;
      mn = '0;
      for (int j = 0; j < 512 / w; j++) mn[j*w + w - 1] = 1'b1;
      v = '{e[1:0], 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 32'd0};
      run(v, mn, gen(32'd77), "R2", got);
      chk(got === mn, "R2 literal", got, mn);
    end

    // R11: mask bits above lane count do not change result
    v = '{2'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 32'd0};
    run(v, gen(32'd21), gen(32'd22), "R11 high mask", got);
    v.mk = 64'h0;
    run(v, gen(32'd21), gen(32'd22), "R11 zero mask", got2);
    chk(got === got2, "R11 compare", got, got2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule